// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words and returns a 32-bit word. Each operand is split into sign, biased exponent (bias 127) and fraction, and a significand is formed with an implied leading one for normal numbers or a leading zero for subnormal numbers. The operand with the larger magnitude sets the starting exponent. The other significand is shifted right by the exponent gap, and the bits that drop out are kept as a sticky bit. The significands are then combined, normalised, rounded to nearest with ties to even, and packed again.

The block is a fixed three-stage pipeline with no backpressure. A request is accepted in any cycle where `in_valid` is high, and its result appears with `out_valid` exactly three cycles later. Requests may be issued back to back. Special operands are handled on a path beside the arithmetic: NaN inputs, infinities of opposite effective sign, and an infinity plus a finite value. Two flags travel with each result: overflow to infinity, and an invalid operation.

Top module: `fpadd_top`

## Requirements
- R1: The word layout is sign in bit 31, biased exponent in bits 30..23 with bias 127, and fraction in bits 22..0. Normal operands are added exactly, then rounded, e.g. 0x41C40000 + 0xC14A0000 = 0x413E0000.
- R2: When `in_sub` is 1, the sign of `in_b` is inverted before any other decision, so the result is a − b (0x3F800000 − 0x40000000 = 0xBF800000).
- R3: Bits shifted out during alignment feed a sticky bit. Rounding is to nearest with ties to even: 1.0 + 2^-24 = 0x3F800000, 0x3F800001 + 2^-24 = 0x3F800002, and 1.0 + a value just above 2^-24 = 0x3F800001.
- R4: If rounding carries out of the significand, the exponent is incremented (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R5: An exact zero result from finite operands is always +0 (0x00000000), including (−0) + (−0).
- R6: Exponent field 0 means a subnormal operand (hidden bit 0, scale equal to exponent 1). Results too small for a normal number are delivered as subnormal numbers, and subnormal sums that reach the normal range come out normal.
- R7: A rounded exponent of 255 or more from finite operands gives infinity with the computed sign, with `out_overflow` = 1.
- R8: If either operand is NaN (exponent 255, fraction nonzero), the result is 0x7FC00000.
- R9: Infinity combined with infinity of opposite effective sign gives 0x7FC00000 with `out_invalid` = 1.
- R10: An infinity combined with a finite value, or with an infinity of the same effective sign, returns that infinity (exponent 255, fraction 0, its effective sign).
- R11: `out_valid` is low during and after reset until a request is made. Each request accepted with `in_valid` produces `out_valid` exactly 3 cycles later, in issue order.
- R12: `out_overflow` and `out_invalid` are never both 1. Both are 0 for every result that does not meet the condition of R7 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| out_valid | output | 1 | Result strobe, three cycles after the request |
| out_result | output | 32 | Sum or difference |
| out_overflow | output | 1 | Finite operands rounded to infinity |
| out_invalid | output | 1 | Infinity minus infinity |

## Verification
Some properties are checked on every cycle: the three-cycle request-to-result spacing, that any NaN result is the single canonical quiet pattern, that the invalid flag comes only with that pattern, that the overflow flag comes only with an infinite result, that the two flags are never both set, and that a zero result is never negative. The numeric cases can only be shown by the bench's directed scenarios, which compare against hand-derived words. These cases are exact sums, sticky and tie-to-even rounding, rounding carry into the exponent, cancellation into subnormal numbers, and the choice among infinities.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;
    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;

    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int GRS_W   = 3;
    localparam int EXT_W   = SIG_W + GRS_W;
    localparam int SUM_W   = EXT_W + 1;
    localparam int EV_W    = EXP_W + 2;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] eff_exp;
        logic [SIG_W-1:0] sig;
        logic             is_inf;
        logic             is_nan;
    } unp_t;

    typedef struct packed {
        logic valid;
        unp_t opa;
        unp_t opb;
    } st1_t;

    typedef struct packed {
        logic              valid;
        logic              special;
        logic              invalid;
        logic [WORD_W-1:0] spec_word;
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SUM_W-1:0]  sum;
    } st2_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] result;
        logic              overflow;
        logic              invalid;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;
endpackage

// File: rtl/fpadd_unpack.sv
`timescale 1ns/1ps
module fpadd_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              flip_sign,
    output unp_t              fields
);
    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac_raw;
    logic              exp_zero;
    logic              exp_full;

    always_comb begin
        exp_raw  = word[WORD_W-2 -: EXP_W];
        frac_raw = word[FRAC_W-1:0];
        exp_zero = (exp_raw == '0);
        exp_full = (exp_raw == EXP_W'(EXP_MAX));

        fields.sign    = word[WORD_W-1] ^ flip_sign;
        fields.eff_exp = exp_zero ? EXP_W'(1) : exp_raw;
        fields.sig     = {~exp_zero, frac_raw};
        fields.is_inf  = exp_full && (frac_raw == '0);
        fields.is_nan  = exp_full && (frac_raw != '0);
    end
endmodule

// File: rtl/fpadd_align.sv
`timescale 1ns/1ps
module fpadd_align
    import fpadd_pkg::*;
(
    input  unp_t              opa,
    input  unp_t              opb,
    output logic              special,
    output logic              invalid,
    output logic [WORD_W-1:0] spec_word,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [SUM_W-1:0]  sum
);
    logic               a_big;
    logic               big_sign;
    logic               small_sign;
    logic [EXP_W-1:0]   big_exp;
    logic [EXP_W-1:0]   small_exp;
    logic [SIG_W-1:0]   big_sig;
    logic [SIG_W-1:0]   small_sig;
    logic [EXP_W-1:0]   gap;
    logic [2*EXT_W-1:0] wide;
    logic [EXT_W-1:0]   shifted;
    logic               sticky;
    logic [SUM_W-1:0]   big_x;
    logic [SUM_W-1:0]   small_x;
    logic               eff_sub;

    // magnitude ordering and right shift of the smaller operand
    always_comb begin
        a_big      = {opa.eff_exp, opa.sig} >= {opb.eff_exp, opb.sig};
        big_sign   = a_big ? opa.sign    : opb.sign;
        small_sign = a_big ? opb.sign    : opa.sign;
        big_exp    = a_big ? opa.eff_exp : opb.eff_exp;
        small_exp  = a_big ? opb.eff_exp : opa.eff_exp;
        big_sig    = a_big ? opa.sig     : opb.sig;
        small_sig  = a_big ? opb.sig     : opa.sig;
        gap        = big_exp - small_exp;

        wide = {small_sig, {GRS_W{1'b0}}, {EXT_W{1'b0}}} >> gap;
        if (gap >= EXP_W'(EXT_W)) begin
            shifted = '0;
            sticky  = |small_sig;
        end else begin
            shifted = wide[2*EXT_W-1:EXT_W];
            sticky  = |wide[EXT_W-1:0];
        end
    end

    // effective add or subtract
    always_comb begin
        eff_sub  = big_sign ^ small_sign;
        big_x    = {1'b0, big_sig, {GRS_W{1'b0}}};
        small_x  = {1'b0, shifted[EXT_W-1:1], shifted[0] | sticky};
        sum      = eff_sub ? (big_x - small_x) : (big_x + small_x);
        res_sign = (sum == '0) ? 1'b0 : big_sign;
        res_exp  = big_exp;
    end

    // special operand classes
    always_comb begin
        special   = 1'b0;
        invalid   = 1'b0;
        spec_word = QNAN_WORD;
        if (opa.is_nan || opb.is_nan) begin
            special = 1'b1;
        end else if (opa.is_inf && opb.is_inf && (opa.sign != opb.sign)) begin
            special = 1'b1;
            invalid = 1'b1;
        end else if (opa.is_inf) begin
            special   = 1'b1;
            spec_word = {opa.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (opb.is_inf) begin
            special   = 1'b1;
            spec_word = {opb.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end
    end
endmodule

// File: rtl/fpadd_round.sv
`timescale 1ns/1ps
module fpadd_round
    import fpadd_pkg::*;
(
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [SUM_W-1:0]  sum,
    output logic [WORD_W-1:0] word,
    output logic              overflow
);
    logic [EV_W-1:0]  lz;
    logic [EV_W-1:0]  room;
    logic [EV_W-1:0]  shl;
    logic [EV_W-1:0]  exp_n;
    logic [EV_W-1:0]  exp_r;
    logic [EXT_W-1:0] norm;
    logic [SIG_W-1:0] mant;
    logic             guard;
    logic             rest;
    logic             bump;
    logic [SIG_W:0]   mant_r;
    logic             carry;
    logic             has_lead;
    logic [FRAC_W-1:0] frac_o;

    // leading-zero count of the sum below the carry position
    always_comb begin
        lz = EV_W'(EXT_W);
        for (int i = 0; i < EXT_W; i++) begin
            if (sum[i]) lz = EV_W'(EXT_W - 1 - i);
        end
    end

    // normalisation: right by one on carry, else left but not below exponent 1
    always_comb begin
        room = {2'b00, exp_in} - EV_W'(1);
        shl  = (lz > room) ? room : lz;
        if (sum[SUM_W-1]) begin
            norm  = {sum[SUM_W-1:2], sum[1] | sum[0]};
            exp_n = {2'b00, exp_in} + EV_W'(1);
        end else begin
            norm  = sum[EXT_W-1:0] << shl;
            exp_n = {2'b00, exp_in} - shl;
        end
    end

    // round to nearest, ties to even
    always_comb begin
        mant   = norm[EXT_W-1:GRS_W];
        guard  = norm[GRS_W-1];
        rest   = |norm[GRS_W-2:0];
        bump   = guard & (rest | mant[0]);
        mant_r = {1'b0, mant} + (SIG_W+1)'(bump);
        carry  = mant_r[SIG_W];
        exp_r  = carry ? (exp_n + EV_W'(1)) : exp_n;
        has_lead = carry | mant_r[SIG_W-1];
        frac_o = carry ? mant_r[SIG_W-1:1] : mant_r[FRAC_W-1:0];
    end

    // packing
    always_comb begin
        overflow = has_lead && (exp_r >= EV_W'(EXP_MAX));
        if (overflow) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (has_lead) begin
            word = {sign, exp_r[EXP_W-1:0], frac_o};
        end else begin
            word = {sign, {EXP_W{1'b0}}, frac_o};
        end
    end
endmodule

// File: rtl/fpadd_top.sv
`timescale 1ns/1ps
module fpadd_top
    import fpadd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic        in_sub,
    output logic        out_valid,
    output logic [31:0] out_result,
    output logic        out_overflow,
    output logic        out_invalid
);
    pipe_t pipe_d;
    pipe_t pipe_q;

    unp_t              a_unp;
    unp_t              b_unp;
    logic              al_special;
    logic              al_invalid;
    logic [WORD_W-1:0] al_spec_word;
    logic              al_sign;
    logic [EXP_W-1:0]  al_exp;
    logic [SUM_W-1:0]  al_sum;
    logic [WORD_W-1:0] rn_word;
    logic              rn_overflow;

    fpadd_unpack u_unp_a (
        .word      (in_a),
        .flip_sign (1'b0),
        .fields    (a_unp)
    );

    fpadd_unpack u_unp_b (
        .word      (in_b),
        .flip_sign (in_sub),
        .fields    (b_unp)
    );

    fpadd_align u_align (
        .opa       (pipe_q.s1.opa),
        .opb       (pipe_q.s1.opb),
        .special   (al_special),
        .invalid   (al_invalid),
        .spec_word (al_spec_word),
        .res_sign  (al_sign),
        .res_exp   (al_exp),
        .sum       (al_sum)
    );

    fpadd_round u_round (
        .sign     (pipe_q.s2.sign),
        .exp_in   (pipe_q.s2.exp),
        .sum      (pipe_q.s2.sum),
        .word     (rn_word),
        .overflow (rn_overflow)
    );

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.valid = in_valid;
        pipe_d.s1.opa   = a_unp;
        pipe_d.s1.opb   = b_unp;

        pipe_d.s2.valid     = pipe_q.s1.valid;
        pipe_d.s2.special   = al_special;
        pipe_d.s2.invalid   = al_invalid;
        pipe_d.s2.spec_word = al_spec_word;
        pipe_d.s2.sign      = al_sign;
        pipe_d.s2.exp       = al_exp;
        pipe_d.s2.sum       = al_sum;

        pipe_d.s3.valid    = pipe_q.s2.valid;
        pipe_d.s3.result   = pipe_q.s2.special ? pipe_q.s2.spec_word : rn_word;
        pipe_d.s3.overflow = ~pipe_q.s2.special & rn_overflow;
        pipe_d.s3.invalid  = pipe_q.s2.special & pipe_q.s2.invalid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid    = pipe_q.s3.valid;
    assign out_result   = pipe_q.s3.result;
    assign out_overflow = pipe_q.s3.overflow;
    assign out_invalid  = pipe_q.s3.invalid;
endmodule

// File: rtl/fpadd_checker.sv
`timescale 1ns/1ps
module fpadd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_overflow,
    input logic        out_invalid
);
    logic [1:0] live_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= 2'd0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R11

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt != 2'd3) |-> !out_valid); // R11

    AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_result[30:23] == 8'hFF) && (out_result[22:0] != 23'd0))
        |-> (out_result == 32'h7FC00000)); // R8

    AST_INVALID_GIVES_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == 32'h7FC00000)); // R9

    AST_OVERFLOW_GIVES_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> (out_result[30:0] == 31'h7F800000)); // R7

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_overflow && out_invalid)); // R12

    AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_result[30:0] == 31'd0)) |-> !out_result[31]); // R5
endmodule

bind fpadd_top fpadd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_overflow (out_overflow),
    .out_invalid  (out_invalid)
);

// File: tb/fpadd_top_tb.sv
`timescale 1ns/1ps
module fpadd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        in_sub = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_overflow;
    logic        out_invalid;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    logic [33:0] q_exp[$];
    int          q_cyc[$];
    string       q_tag[$];

    fpadd_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_a         (in_a),
        .in_b         (in_b),
        .in_sub       (in_sub),
        .out_valid    (out_valid),
        .out_result   (out_result),
        .out_overflow (out_overflow),
        .out_invalid  (out_invalid)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // driver: one request per call, expected item pushed to the scoreboard
    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input logic [31:0] res, input logic ovf, input logic inv,
                         input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        in_sub   = sub;
        q_exp.push_back({res, ovf, inv});
        q_cyc.push_back(cyc + 3);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops and compares each result as it appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_tests++;
            if (q_exp.size() == 0) begin
                n_fail++;
                $display("FAIL R11: result %h with no request pending (expected none)", out_result);
            end else begin
                logic [33:0] e;
                int          ec;
                string       t;
                e  = q_exp.pop_front();
                ec = q_cyc.pop_front();
                t  = q_tag.pop_front();
                if ({out_result, out_overflow, out_invalid} !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %h ovf=%b inv=%b, expected %h ovf=%b inv=%b",
                             t, out_result, out_overflow, out_invalid, e[33:2], e[1], e[0]);
                end
                n_tests++;
                if (cyc != ec) begin
                    n_fail++;
                    $display("FAIL R11: result at cycle %0d, expected cycle %0d", cyc, ec);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (expected completion)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: out_valid=%b during reset, expected 0", out_valid);
        end
        rst_n = 1'b1;
        idle(3);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: out_valid=%b after reset with no request, expected 0", out_valid);
        end

        // R1: plain sums, back to back
        drive(32'h41C40000, 32'hC14A0000, 1'b0, 32'h413E0000, 1'b0, 1'b0, "R1 24.5+-12.625");
        drive(32'hC14A0000, 32'hC14A0000, 1'b0, 32'hC1CA0000, 1'b0, 1'b0, "R1 neg+neg");
        drive(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R1 1+1");
        // R2: subtraction flips the sign of b
        drive(32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, 1'b0, 1'b0, "R2 1-2");
        drive(32'h41C40000, 32'hC14A0000, 1'b1, 32'h42148000, 1'b0, 1'b0, "R2 24.5--12.625");
        idle(2);
        // R3: sticky and ties to even
        drive(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R3 tie to even down");
        drive(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, "R3 tie to even up");
        drive(32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0, "R3 sticky above half");
        drive(32'h3F800000, 32'h00000001, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R3 huge gap");
        // R4: rounding carry
        drive(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R4 round carry");
        idle(1);
        // R5: exact zero is +0
        drive(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 1'b0, "R5 1-1");
        drive(32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0, "R5 -0+-0");
        drive(32'h41C40000, 32'hC1C40000, 1'b0, 32'h00000000, 1'b0, 1'b0, "R5 x+-x");
        // R6: subnormals
        drive(32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 1'b0, 1'b0, "R6 sub+sub");
        drive(32'h00400000, 32'h00400000, 1'b0, 32'h00800000, 1'b0, 1'b0, "R6 sub to normal");
        drive(32'h00800001, 32'h00800000, 1'b1, 32'h00000001, 1'b0, 1'b0, "R6 cancel to sub");
        idle(3);
        // R7: overflow
        drive(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R7 +overflow");
        drive(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1, 1'b0, "R7 -overflow");
        // R8: NaN inputs
        drive(32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, "R8 nan a");
        drive(32'h3F800000, 32'hFF800001, 1'b1, 32'h7FC00000, 1'b0, 1'b0, "R8 nan b");
        // R9: inf - inf
        drive(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0, 1'b1, "R9 inf-inf");
        drive(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 1'b0, 1'b1, "R9 inf+-inf");
        // R10: infinity results
        drive(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R10 inf+1");
        drive(32'hC0A00000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0, "R10 -5-inf");
        drive(32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, 1'b0, 1'b0, "R10 -inf+-inf");
        // R12: flags clear on an ordinary result right after flagged ones
        drive(32'h40000000, 32'h3F800000, 1'b1, 32'h3F800000, 1'b0, 1'b0, "R12 flags clear");
        idle(6);

        n_tests++;
        if (q_exp.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d results missing, expected 0", q_exp.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule